// File: doc/BRIEF.md
# Multi-Lane Serial Flash Byte Shifter

This block moves one byte at a time between a command sequencer and a serial flash device over one, two or four data lines. For each byte the sequencer names the phase (opcode, address, dummy or data), gives the byte, says whether data flows toward the device or away from it, and supplies a 3-bit interface-type code. From the code and the phase, the block picks how many lines the byte uses. It then toggles the serial clock the required number of times, drives or releases each data line, and assembles received bits into a byte.

Chip select, the choice of which phases occur, and byte counting are left to the sequencer. The sequencer pulses `start` while the block is idle and waits for `done` before it issues the next byte. One serial clock period takes two system clock cycles: the low half comes first and the high half second. Outgoing bits change only at the start of a low half. Incoming bits are captured at the end of a high half.

Top module: `flash_lane_shifter`

## Requirements
- R1: While reset is held, and in the first cycle after it, `sclk` is 0, `ioOe` is 4'b0000, `ioOut` is 4'b0000, and `done` and `rxValid` are 0.
- R2: An opcode byte (phase code 0) is always sent on a single lane for every interface code. It goes out MSB first on io0, with `ioOe` = 4'b0001, over 8 serial clocks.
- R3: An address byte (phase code 1) is driven on one lane (io0) for interface codes 0, 1 and 3, on two lanes for code 2, and on four lanes for code 4.
- R4: A data byte (phase code 3) uses one lane for interface code 0, two lanes for codes 1 and 2, and four lanes for codes 3 and 4.
- R5: On two lanes each serial clock carries a bit pair, with io1 holding the higher bit, so bits 7:6 go first. On four lanes io3..io0 carry a nibble, so bits 7:4 go first.
- R6: Each serial clock spans two system cycles with `sclk` low and then high. A byte takes 8, 4 or 2 serial clocks on 1, 2 or 4 lanes. Outputs hold steady while `sclk` is high. `done` is high for exactly the one cycle that follows the final high half.
- R7: A dummy byte (phase code 2) releases every line (`ioOe` = 0, `ioOut` = 0). It runs for as many serial clocks as an address byte would under the same interface code.
- R8: A data byte with `readDir` = 1 releases every line. In single-lane mode it samples io1. On two lanes it samples io1:io0, and on four lanes io3:io0, with the first sampled group forming the top bits. `rxByte` holds the received byte and `rxValid` is high in the same cycle as `done`.
- R9: A `start` pulse that arrives while a byte is in progress is ignored. The current byte finishes unchanged and no second byte follows.
- R10: While idle, `sclk` is 0 and all lines are released. Any line not driven reads 0 on `ioOut`.
- R11: Interface codes 5, 6 and 7 behave like code 0, with every phase on a single lane.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin one byte; accepted only while idle |
| phase | input | 2 | 0 opcode, 1 address, 2 dummy, 3 data |
| readDir | input | 1 | 1 = data byte flows from the device |
| ifType | input | 3 | Interface-type code selecting lane widths |
| txByte | input | 8 | Byte to send, captured with `start` |
| ioIn | input | 4 | Sampled levels of data lines io3..io0 |
| sclk | output | 1 | Serial clock |
| ioOut | output | 4 | Output values for io3..io0 |
| ioOe | output | 4 | Per-line output enables for io3..io0 |
| done | output | 1 | One-cycle pulse when a byte ends |
| rxByte | output | 8 | Last received byte |
| rxValid | output | 1 | Pulse with `done` after a read data byte |

## Verification
A `start` sampled at clock edge E0 brings up the first low half in the cycle after E0. Slot k then shows its low half in cycle 2k+1 and its high half in cycle 2k+2. `done`, and `rxValid` for reads, appear in cycle 2N+1 for a byte of N slots, and the block is idle again one cycle later. The bench drives every input on the falling clock edge and samples every output on the next falling edge. It steps through the byte one half-slot per falling edge, comparing lines and enables in each half. It expects `done` at exactly the falling edge after the last high half, which pins the clock count. For reads it changes `ioIn` during each low half and holds it through the high half in which the sample is taken.

// File: rtl/flash_lane_pkg.sv
package flash_lane_pkg;

  localparam int BYTE_BITS = 8;
  localparam int IO_LINES  = 4;

  typedef enum logic [1:0] {
    PH_CMD   = 2'd0,
    PH_ADDR  = 2'd1,
    PH_DUMMY = 2'd2,
    PH_DATA  = 2'd3
  } phase_t;

  // Value is log2 of the lane count so it doubles as a shift amount.
  typedef enum logic [1:0] {
    LANE_X1 = 2'd0,
    LANE_X2 = 2'd1,
    LANE_X4 = 2'd2
  } laneMode_t;

  typedef struct packed {
    logic      load;     // byte accepted this cycle
    logic      advance;  // end of a high half: shift one group
    logic      finish;   // advance on the final slot
    logic      drive;    // lines are driven for this byte
    logic      capture;  // incoming group is sampled for this byte
    laneMode_t lanes;    // lane width of the byte in progress
  } ctrlStrobes_t;

  function automatic laneMode_t pickLanes(input logic [2:0] code, input phase_t ph);
    laneMode_t mode;
    mode = LANE_X1;
    unique case (ph)
      PH_CMD: mode = LANE_X1;
      PH_ADDR, PH_DUMMY: begin
        if (code == 3'd2)      mode = LANE_X2;
        else if (code == 3'd4) mode = LANE_X4;
        else                   mode = LANE_X1;
      end
      PH_DATA: begin
        case (code)
          3'd1, 3'd2: mode = LANE_X2;
          3'd3, 3'd4: mode = LANE_X4;
          default:    mode = LANE_X1;
        endcase
      end
      default: mode = LANE_X1;
    endcase
    return mode;
  endfunction

endpackage

// File: rtl/flash_lane_ctrl.sv
module flash_lane_ctrl
  import flash_lane_pkg::*;
#(
  parameter int BITS = BYTE_BITS
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic [1:0]   phase,
  input  logic         readDir,
  input  logic [2:0]   ifType,
  output ctrlStrobes_t strobes,
  output logic         sclk,
  output logic         busy,
  output logic         done,
  output logic         rxValid
);

  localparam int CNT_W = $clog2(BITS);

  logic             busyQ;
  logic             halfQ;
  logic [CNT_W-1:0] slotQ;
  logic [CNT_W-1:0] lastSlot;
  laneMode_t        lanesQ;
  logic             driveQ;
  logic             captureQ;
  logic             doneQ;
  logic             rxValidQ;

  logic      loadNow;
  logic      advanceNow;
  logic      finishNow;
  phase_t    phaseIn;
  laneMode_t lanesIn;
  logic      driveIn;
  logic      captureIn;

  assign phaseIn    = phase_t'(phase);
  assign lanesIn    = pickLanes(ifType, phaseIn);
  assign driveIn    = (phaseIn == PH_CMD) || (phaseIn == PH_ADDR) ||
                      ((phaseIn == PH_DATA) && !readDir);
  assign captureIn  = (phaseIn == PH_DATA) && readDir;

  assign lastSlot   = CNT_W'((BITS >> lanesQ) - 1);
  assign loadNow    = start && !busyQ;
  assign advanceNow = busyQ && halfQ;
  assign finishNow  = advanceNow && (slotQ == lastSlot);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ    <= 1'b0;
      halfQ    <= 1'b0;
      slotQ    <= '0;
      lanesQ   <= LANE_X1;
      driveQ   <= 1'b0;
      captureQ <= 1'b0;
      doneQ    <= 1'b0;
      rxValidQ <= 1'b0;
    end else begin
      doneQ    <= finishNow;
      rxValidQ <= finishNow && captureQ;
      if (loadNow) begin
        busyQ    <= 1'b1;
        halfQ    <= 1'b0;
        slotQ    <= '0;
        lanesQ   <= lanesIn;
        driveQ   <= driveIn;
        captureQ <= captureIn;
      end else if (busyQ) begin
        halfQ <= !halfQ;
        if (halfQ) begin
          if (finishNow) begin
            busyQ <= 1'b0;
            slotQ <= '0;
          end else begin
            slotQ <= slotQ + 1'b1;
          end
        end
      end
    end
  end

  always_comb begin
    strobes.load    = loadNow;
    strobes.advance = advanceNow;
    strobes.finish  = finishNow;
    strobes.drive   = busyQ && driveQ;
    strobes.capture = busyQ && captureQ;
    strobes.lanes   = lanesQ;
  end

  assign sclk    = busyQ && halfQ;
  assign busy    = busyQ;
  assign done    = doneQ;
  assign rxValid = rxValidQ;

endmodule

// File: rtl/flash_lane_dp.sv
module flash_lane_dp
  import flash_lane_pkg::*;
#(
  parameter int BITS  = BYTE_BITS,
  parameter int LINES = IO_LINES
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     strobes,
  input  logic [BITS-1:0]  txByte,
  input  logic [LINES-1:0] ioIn,
  output logic [LINES-1:0] ioOut,
  output logic [LINES-1:0] ioOe,
  output logic [BITS-1:0]  rxByte
);

  logic [BITS-1:0]  txShift;
  logic [BITS-1:0]  rxShift;
  logic [BITS-1:0]  rxNext;
  logic [BITS-1:0]  txNext;
  logic [BITS-1:0]  rxHold;
  logic [LINES-1:0] laneMask;
  logic [LINES-1:0] laneGroup;

  // Output group and enable mask for each lane width.
  always_comb begin
    laneGroup = '0;
    laneMask  = '0;
    txNext    = txShift;
    rxNext    = rxShift;
    unique case (strobes.lanes)
      LANE_X2: begin
        laneGroup[1:0] = txShift[BITS-1 -: 2];
        laneMask       = LINES'(2'b11);
        txNext         = {txShift[BITS-3:0], 2'b00};
        rxNext         = {rxShift[BITS-3:0], ioIn[1:0]};
      end
      LANE_X4: begin
        laneGroup[3:0] = txShift[BITS-1 -: 4];
        laneMask       = LINES'(4'b1111);
        txNext         = {txShift[BITS-5:0], 4'b0000};
        rxNext         = {rxShift[BITS-5:0], ioIn[3:0]};
      end
      default: begin
        laneGroup[0] = txShift[BITS-1];
        laneMask     = LINES'(1'b1);
        txNext       = {txShift[BITS-2:0], 1'b0};
        rxNext       = {rxShift[BITS-2:0], ioIn[1]};
      end
    endcase
  end

  genvar lineIdx;
  generate
    for (lineIdx = 0; lineIdx < LINES; lineIdx++) begin : g_line
      assign ioOe[lineIdx]  = strobes.drive && laneMask[lineIdx];
      assign ioOut[lineIdx] = strobes.drive && laneMask[lineIdx] && laneGroup[lineIdx];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
      rxHold  <= '0;
    end else begin
      if (strobes.load) begin
        txShift <= txByte;
        rxShift <= '0;
      end else if (strobes.advance) begin
        txShift <= txNext;
        if (strobes.capture) begin
          rxShift <= rxNext;
          if (strobes.finish) rxHold <= rxNext;
        end
      end
    end
  end

  assign rxByte = rxHold;

endmodule

// File: rtl/flash_lane_shifter.sv
module flash_lane_shifter
  import flash_lane_pkg::*;
#(
  parameter int BITS  = BYTE_BITS,
  parameter int LINES = IO_LINES
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [1:0]       phase,
  input  logic             readDir,
  input  logic [2:0]       ifType,
  input  logic [BITS-1:0]  txByte,
  input  logic [LINES-1:0] ioIn,
  output logic             sclk,
  output logic [LINES-1:0] ioOut,
  output logic [LINES-1:0] ioOe,
  output logic             done,
  output logic [BITS-1:0]  rxByte,
  output logic             rxValid
);

  ctrlStrobes_t strobes;
  logic         busy;

  flash_lane_ctrl #(.BITS(BITS)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .phase   (phase),
    .readDir (readDir),
    .ifType  (ifType),
    .strobes (strobes),
    .sclk    (sclk),
    .busy    (busy),
    .done    (done),
    .rxValid (rxValid)
  );

  flash_lane_dp #(.BITS(BITS), .LINES(LINES)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .txByte  (txByte),
    .ioIn    (ioIn),
    .ioOut   (ioOut),
    .ioOe    (ioOe),
    .rxByte  (rxByte)
  );

endmodule

// File: rtl/flash_lane_checker.sv
module flash_lane_checker #(
  parameter int LINES = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             busy,
  input logic             sclk,
  input logic [LINES-1:0] ioOut,
  input logic [LINES-1:0] ioOe,
  input logic             done,
  input logic             rxValid
);

  assert_idle_released_R10: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (ioOe == '0) && (ioOut == '0) && !sclk);

  assert_stable_high_R6: assert property (@(posedge clk) disable iff (!rstN)
    sclk |-> $stable(ioOut) && $stable(ioOe));

  assert_done_after_high_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(sclk) && !sclk);

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_rx_with_done_R8: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> done);

  assert_oe_shape_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ioOe == LINES'(0)) || (ioOe == LINES'(1)) || (ioOe == LINES'(3)) || (ioOe == LINES'(15)));

  assert_out_within_oe_R10: assert property (@(posedge clk) disable iff (!rstN)
    (ioOut & ~ioOe) == '0);

endmodule

bind flash_lane_shifter flash_lane_checker #(.LINES(LINES)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .busy    (busy),
  .sclk    (sclk),
  .ioOut   (ioOut),
  .ioOe    (ioOe),
  .done    (done),
  .rxValid (rxValid)
);

// File: tb/flash_lane_shifter_bench.sv
module flash_lane_shifter_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic [1:0] phase = 2'd0;
  logic       readDir = 1'b0;
  logic [2:0] ifType = 3'd0;
  logic [7:0] txByte = 8'h00;
  logic [3:0] ioIn = 4'h0;
  logic       sclk;
  logic [3:0] ioOut;
  logic [3:0] ioOe;
  logic       done;
  logic [7:0] rxByte;
  logic       rxValid;

  int testCount = 0;
  int failCount = 0;

  always #4 clk = !clk;

  flash_lane_shifter u_flash_lane_shifter (
    .clk(clk), .rstN(rstN), .start(start), .phase(phase), .readDir(readDir),
    .ifType(ifType), .txByte(txByte), .ioIn(ioIn), .sclk(sclk), .ioOut(ioOut),
    .ioOe(ioOe), .done(done), .rxByte(rxByte), .rxValid(rxValid)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Lane count from the requirement tables (R2, R3, R4, R7, R11).
  function automatic int expLanes(input logic [2:0] code, input logic [1:0] ph);
    logic [2:0] c;
    c = (code > 3'd4) ? 3'd0 : code;
    if (ph == 2'd0) return 1;
    if (ph == 2'd3) return (c == 3'd1 || c == 3'd2) ? 2 : (c == 3'd3 || c == 3'd4) ? 4 : 1;
    return (c == 3'd2) ? 2 : (c == 3'd4) ? 4 : 1;
  endfunction

  // One byte, checked half-slot by half-slot; poke raises a second start mid-byte (R9).
  task automatic runByte(input string req, input logic [1:0] ph, input logic rd,
                         input logic [2:0] code, input logic [7:0] b, input bit poke);
    int   lanes;
    int   slots;
    bit   drives;
    bit   reads;
    logic [3:0] mask;
    logic [3:0] expOut;
    logic [3:0] expOe;
    logic [7:0] tmp;
    lanes  = expLanes(code, ph);
    slots  = 8 / lanes;
    drives = (ph == 2'd0) || (ph == 2'd1) || (ph == 2'd3 && !rd);
    reads  = (ph == 2'd3) && rd;
    mask   = (lanes == 1) ? 4'b0001 : (lanes == 2) ? 4'b0011 : 4'b1111;
    phase = ph; readDir = rd; ifType = code; txByte = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    txByte = 8'h00;
    for (int s = 0; s < slots; s++) begin
      tmp = b << (s * lanes);
      if (lanes == 1)      expOut = {3'b000, tmp[7]};
      else if (lanes == 2) expOut = {2'b00, tmp[7:6]};
      else                 expOut = tmp[7:4];
      expOe  = drives ? mask : 4'b0000;
      if (!drives) expOut = 4'b0000;
      if (reads) begin
        if (lanes == 1)      ioIn = {2'b00, tmp[7], !tmp[7]};
        else if (lanes == 2) ioIn = {!tmp[7], !tmp[6], tmp[7], tmp[6]};
        else                 ioIn = tmp[7:4];
      end
      if (poke && s == 1) begin
        start = 1'b1; phase = 2'd3; readDir = 1'b0; txByte = 8'h3C;
      end
      chk(req, "sclk low half", sclk, 1'b0);
      chk(req, "done early", done, 1'b0);
      chk(req, "ioOe low half", ioOe, expOe);
      chk(req, "ioOut low half", ioOut, expOut);
      @(negedge clk);
      start = 1'b0;
      chk(req, "sclk high half", sclk, 1'b1);
      chk(req, "ioOe high half", ioOe, expOe);
      chk(req, "ioOut high half", ioOut, expOut);
      @(negedge clk);
    end
    chk(req, "done at end", done, 1'b1);
    chk(req, "sclk at end", sclk, 1'b0);
    chk(req, "ioOe at end", ioOe, 4'b0000);
    chk(req, "rxValid at end", rxValid, reads);
    if (reads) chk(req, "rxByte", rxByte, b);
    ioIn = 4'h0;
    @(negedge clk);
    chk(req, "done one cycle", done, 1'b0);
    chk("R10", "idle sclk", sclk, 1'b0);
    chk("R10", "idle ioOe", ioOe, 4'b0000);
    chk("R10", "idle ioOut", ioOut, 4'b0000);
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    chk("R1", "sclk in reset", sclk, 1'b0);
    chk("R1", "ioOe in reset", ioOe, 4'b0000);
    chk("R1", "ioOut in reset", ioOut, 4'b0000);
    chk("R1", "done in reset", done, 1'b0);
    chk("R1", "rxValid in reset", rxValid, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "sclk after reset", sclk, 1'b0);
    chk("R1", "ioOe after reset", ioOe, 4'b0000);
  endtask

  task automatic testCommand();
    runByte("R2", 2'd0, 1'b0, 3'd0, 8'h9F, 1'b0);
    runByte("R2", 2'd0, 1'b0, 3'd4, 8'hEB, 1'b0);
    runByte("R2", 2'd0, 1'b1, 3'd3, 8'h6B, 1'b0);
  endtask

  task automatic testAddress();
    runByte("R3", 2'd1, 1'b0, 3'd0, 8'hA5, 1'b0);
    runByte("R3", 2'd1, 1'b0, 3'd1, 8'h3C, 1'b0);
    runByte("R3", 2'd1, 1'b0, 3'd3, 8'hC3, 1'b0);
    runByte("R3", 2'd1, 1'b0, 3'd2, 8'hB4, 1'b0);
    runByte("R3", 2'd1, 1'b0, 3'd4, 8'h5E, 1'b0);
  endtask

  task automatic testDataWrite();
    runByte("R4", 2'd3, 1'b0, 3'd0, 8'h81, 1'b0);
    runByte("R5", 2'd3, 1'b0, 3'd1, 8'hC6, 1'b0);
    runByte("R5", 2'd3, 1'b0, 3'd2, 8'h1B, 1'b0);
    runByte("R5", 2'd3, 1'b0, 3'd3, 8'h7E, 1'b0);
    runByte("R4", 2'd3, 1'b0, 3'd4, 8'hD2, 1'b0);
  endtask

  task automatic testDataRead();
    runByte("R8", 2'd3, 1'b1, 3'd0, 8'hB2, 1'b0);
    runByte("R8", 2'd3, 1'b1, 3'd1, 8'h4D, 1'b0);
    runByte("R8", 2'd3, 1'b1, 3'd2, 8'hE1, 1'b0);
    runByte("R8", 2'd3, 1'b1, 3'd3, 8'h96, 1'b0);
    runByte("R8", 2'd3, 1'b1, 3'd4, 8'h2F, 1'b0);
  endtask

  task automatic testDummy();
    runByte("R7", 2'd2, 1'b0, 3'd0, 8'hFF, 1'b0);
    runByte("R7", 2'd2, 1'b0, 3'd3, 8'hFF, 1'b0);
    runByte("R7", 2'd2, 1'b0, 3'd2, 8'hAA, 1'b0);
    runByte("R7", 2'd2, 1'b1, 3'd4, 8'h55, 1'b0);
  endtask

  task automatic testReservedCodes();
    runByte("R11", 2'd1, 1'b0, 3'd5, 8'h69, 1'b0);
    runByte("R11", 2'd3, 1'b0, 3'd6, 8'h93, 1'b0);
    runByte("R11", 2'd3, 1'b1, 3'd7, 8'hC5, 1'b0);
    runByte("R11", 2'd2, 1'b0, 3'd7, 8'h00, 1'b0);
  endtask

  task automatic testBusyIgnore();
    runByte("R9", 2'd0, 1'b0, 3'd0, 8'hA5, 1'b1);
    runByte("R9", 2'd1, 1'b0, 3'd4, 8'h71, 1'b1);
    repeat (4) begin
      @(negedge clk);
      chk("R9", "no second byte sclk", sclk, 1'b0);
      chk("R9", "no second byte ioOe", ioOe, 4'b0000);
      chk("R9", "no second byte done", done, 1'b0);
    end
  endtask

  initial begin
    testReset();
    testCommand();
    testAddress();
    testDataWrite();
    testDataRead();
    testDummy();
    testReservedCodes();
    testBusyIgnore();
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    testCount++;
    failCount++;
    $display("FAIL watchdog R1..all actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule